// File: doc/BRIEF.md
# Switchable-Length LFSR Noise Source

This block produces a one-bit pseudo-random stream meant to drive an analog filter that turns it into audio-band white noise. It is a Fibonacci-form linear feedback shift register. One feedback bit is formed from a set of tapped stages and enters at the head of the chain, and every other stage moves one place along. The chain does not advance on every clock. A divider issues a step tick once every `DIV_RATIO` system clocks. The default of 96 turns a 9.6 MHz clock into a 100 kHz step rate.

A static select pin picks the chain length: 16 stages when high, 24 stages when low. Each length has its own tap set, and both give a maximal-length sequence. The select pin passes through a two-flop synchronizer. Any change seen after synchronization makes the next step tick reload the chain to zero instead of shifting it. The feedback is an XNOR, so the stuck state is all ones, and the block leaves that state by loading zero. A one-cycle strobe marks each cycle whose closing edge updates the chain, so a model can follow the design step by step.

Top module: `noise_lfsr_top`

## Requirements
- R1: While `rst` is high at a clock edge, the chain clears to all zeros and the divider to zero. After reset, `noise_out` is 0 and `step_strobe` is 0.
- R2: `step_strobe` is high for exactly one cycle out of every `DIV_RATIO` cycles. Counting the first edge after reset release as edge 1, it is high in the cycle that ends with edge `DIV_RATIO`.
- R3: The chain changes only at an edge that ends a cycle in which `step_strobe` is high. At every other edge `noise_out` holds its value.
- R4: `noise_out` is stage 1 of the chain, and stage 1 receives the feedback bit. At a normal step, stage k+1 takes the old value of stage k.
- R5: With 16 stages, the feedback is the XNOR of stages 2, 3, 5 and 16. From reset, the output sequence repeats with a period of 65535 steps.
- R6: With 24 stages, the feedback is the XNOR of stages 17, 22, 23 and 24, which gives a maximal sequence of 2^24-1 steps.
- R7: A high level on `len_short` selects 16 stages and a low level selects 24 stages.
- R8: With 16 stages, stages 17 to 24 are held at zero and do not affect the feedback.
- R9: If all active stages are ones at a step, that step loads all zeros. From reset, the 16-stage output never shows more than 15 ones in a row.
- R10: `len_short` is sampled through two flip-flops. When the synchronized value differs from its previous value, the change is latched. The next step then loads all zeros and uses the new length from then on. A step that comes before the synchronized change is seen shifts with the old length.
- R11: When the synchronized change first appears in the same cycle as a step tick, that step reloads to zero rather than shifting, and `step_strobe` is still high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| len_short | input | 1 | Length select: 1 = 16 stages, 0 = 24 stages (asynchronous) |
| noise_out | output | 1 | Stage 1 of the chain |
| step_strobe | output | 1 | High in the cycle whose closing edge updates the chain |

## Verification
The length-change reload and the regular step tick can fall in the same cycle. In that cycle the chain must load zero instead of shifting. The bench provokes this by toggling the select pin a chosen number of cycles before a known tick: one, two, three and five cycles ahead. With a two-cycle lead, the synchronized edge lands exactly on the tick. The bench counts edges from the toggle to work out whether that tick must shift with the old length or reload. It then judges the output after the step against zero or against its own model. A sweep of the full 16-stage period on a fast-divider instance checks the period, the tap set and the bound on runs of ones.

// File: rtl/noise_lfsr_pkg.sv
package noise_lfsr_pkg;
  localparam int unsigned LONG_LEN  = 24;
  localparam int unsigned SHORT_LEN = 16;

  typedef logic [LONG_LEN-1:0] chain_t;

  // Bit k-1 holds stage k.
  localparam chain_t SHORT_TAPS = chain_t'((1 << 1) | (1 << 2) | (1 << 4) | (1 << 15));
  localparam chain_t LONG_TAPS  = chain_t'((1 << 16) | (1 << 21) | (1 << 22) | (1 << 23));

  // Stages that take part in the selected length.
  function automatic chain_t active_mask(input logic short_mode);
    chain_t m;
    m = short_mode ? ((chain_t'(1) << SHORT_LEN) - chain_t'(1)) : '1;
    return m;
  endfunction

  // XNOR of the tapped stages.
  function automatic logic feedback_bit(input chain_t s, input logic short_mode);
    chain_t t;
    t = short_mode ? SHORT_TAPS : LONG_TAPS;
    return ~(^(s & t));
  endfunction

  // Move every stage one place along and put the new bit into stage 1.
  function automatic chain_t shift_in(input chain_t s, input logic b, input chain_t m);
    return {s[LONG_LEN-2:0], b} & m;
  endfunction
endpackage

// File: rtl/noise_tick_div.sv
module noise_tick_div #(
  parameter int unsigned DIV_RATIO = 96
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + CW'(1);
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R2
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R2
endmodule

// File: rtl/noise_len_sync.sv
module noise_len_sync (
  input  logic clk,
  input  logic rst,
  input  logic sel_async,
  input  logic tick,
  output logic short_mode,
  output logic reload
);
  logic meta_q, sync_q, prev_q, pend_q;
  logic change;

  assign change     = sync_q ^ prev_q;
  assign short_mode = sync_q;
  assign reload     = tick & (pend_q | change);

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= sel_async;
      sync_q <= sel_async;
      prev_q <= sel_async;
      pend_q <= 1'b0;
    end else begin
      meta_q <= sel_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
      pend_q <= (pend_q | change) & ~tick;
    end
  end

  AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
    (change && !tick) |=> pend_q); // R10
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (rst)
    tick |=> !pend_q); // R10
endmodule

// File: rtl/noise_lfsr_core.sv
module noise_lfsr_core
  import noise_lfsr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic short_mode,
  input  logic reload,
  output logic noise
);
  chain_t chain_q, chain_d, mask;
  logic   lock_hit, fb;

  assign mask     = active_mask(short_mode);
  assign lock_hit = ((chain_q & mask) == mask);
  assign fb       = feedback_bit(chain_q, short_mode);
  assign noise    = chain_q[0];

  always_comb begin
    chain_d = chain_q;
    if (tick) begin
      if (reload || lock_hit) chain_d = '0;
      else                    chain_d = shift_in(chain_q, fb, mask);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= chain_d;
  end

  AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(chain_q)); // R3
  AST_SHIFT_LOW: assert property (@(posedge clk) disable iff (rst)
    (tick && !reload && !lock_hit) |=>
      chain_q[SHORT_LEN-1:1] == $past(chain_q[SHORT_LEN-2:0])); // R4
  AST_SHIFT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (tick && !reload && !lock_hit && !short_mode) |=>
      chain_q[LONG_LEN-1:SHORT_LEN] == $past(chain_q[LONG_LEN-2:SHORT_LEN-1])); // R6
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick && short_mode) |=> chain_q[LONG_LEN-1:SHORT_LEN] == '0); // R8
  AST_LOCK_ESCAPE: assert property (@(posedge clk) disable iff (rst)
    (tick && lock_hit) |=> chain_q == '0); // R9
  AST_RELOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (tick && reload) |=> chain_q == '0); // R11
endmodule

// File: rtl/noise_lfsr_top.sv
module noise_lfsr_top #(
  parameter int unsigned DIV_RATIO = 96
) (
  input  logic clk,
  input  logic rst,
  input  logic len_short,
  output logic noise_out,
  output logic step_strobe
);
  logic tick, short_mode, reload;

  noise_tick_div #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  noise_len_sync u_sync (
    .clk        (clk),
    .rst        (rst),
    .sel_async  (len_short),
    .tick       (tick),
    .short_mode (short_mode),
    .reload     (reload)
  );

  noise_lfsr_core u_core (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .short_mode (short_mode),
    .reload     (reload),
    .noise      (noise_out)
  );

  assign step_strobe = tick;

  AST_STROBE_UPDATES: assert property (@(posedge clk) disable iff (rst)
    (!step_strobe) |=> $stable(noise_out)); // R3
endmodule

// File: tb/test_noise_lfsr_top.sv
module test_noise_lfsr_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, sel_s, sel_f;
  logic noise_s, stb_s, noise_f, stb_f;
  int   checks = 0, fails = 0;
  bit   finished = 1'b0;
  logic [23:0] model_s, model_f;
  bit   mode_s, mode_f;

  noise_lfsr_top i_noise_lfsr_top (
    .clk(clk), .rst(rst), .len_short(sel_s), .noise_out(noise_s), .step_strobe(stb_s));

  noise_lfsr_top #(.DIV_RATIO(2)) i_noise_lfsr_top_fast (
    .clk(clk), .rst(rst), .len_short(sel_f), .noise_out(noise_f), .step_strobe(stb_f));

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference step: tap list per length, XNOR, escape from all ones.
  function automatic logic [23:0] ref_step(input logic [23:0] s, input bit short);
    int taps[4];
    int len;
    logic x, lock;
    logic [23:0] n;
    if (short) begin taps = '{2, 3, 5, 16}; len = 16; end
    else       begin taps = '{17, 22, 23, 24}; len = 24; end
    lock = 1'b1;
    for (int k = 0; k < len; k++) lock &= s[k];
    if (lock) return 24'h0;
    x = 1'b1;
    for (int i = 0; i < 4; i++) x ^= s[taps[i]-1];
    n = {s[22:0], x};
    if (short) n[23:16] = 8'h0;
    return n;
  endfunction

  task automatic slow_advance(input string tag);
    if (stb_s) begin
      model_s = ref_step(model_s, mode_s);
      @(negedge clk);
      check(noise_s == model_s[0], tag, 24'(noise_s), 24'(model_s[0]));
    end else begin
      @(negedge clk);
      check(noise_s == model_s[0], "R3 hold", 24'(noise_s), 24'(model_s[0]));
    end
  endtask

  // Toggle select m cycles before a tick, then judge the affected tick.
  task automatic slow_switch(input bit new_sel, input int m);
    int  j;
    bit  done;
    while (!stb_s) slow_advance("R4");
    slow_advance("R4");
    repeat (95 - m) slow_advance("R4");
    sel_s = new_sel;
    j = 0;
    done = 1'b0;
    while (!done) begin
      if (stb_s) begin
        check(1'b1, "R11 strobe seen", 24'(stb_s), 24'(1));
        if (j + 1 >= 3) begin
          model_s = 24'h0;
          mode_s  = new_sel;
          @(negedge clk); j++;
          check(noise_s == 1'b0, (m == 2) ? "R11 reload on coinciding tick" : "R10 reload",
                24'(noise_s), 24'(0));
          done = 1'b1;
        end else begin
          model_s = ref_step(model_s, mode_s);
          @(negedge clk); j++;
          check(noise_s == model_s[0], "R10 old length before sync", 24'(noise_s), 24'(model_s[0]));
        end
      end else begin
        @(negedge clk); j++;
        check(noise_s == model_s[0], "R3 hold", 24'(noise_s), 24'(model_s[0]));
      end
    end
    repeat (30 * 96) slow_advance(new_sel ? "R7 R5 short after switch" : "R7 R6 long after switch");
  endtask

  task automatic slow_proc();
    model_s = 24'h0;
    mode_s  = 1'b0;
    for (int n = 0; n < 3 * 96 + 5; n++) begin
      check(stb_s == ((n % 96) == 95), "R2 strobe timing", 24'(stb_s), 24'((n % 96) == 95));
      slow_advance("R4 R6 long step");
    end
    slow_switch(1'b1, 1);
    slow_switch(1'b0, 2);
    slow_switch(1'b1, 3);
    slow_switch(1'b0, 5);
  endtask

  task automatic fast_step(input string tag);
    while (!stb_f) @(negedge clk);
    model_f = ref_step(model_f, mode_f);
    @(negedge clk);
    check(noise_f == model_f[0], tag, 24'(noise_f), 24'(model_f[0]));
  endtask

  task automatic fast_proc();
    logic hist[64];
    int   run, max_run, j;
    bit   done;
    model_f = 24'h0;
    mode_f  = 1'b1;
    run = 0;
    max_run = 0;
    for (int s = 1; s <= 65535 + 64; s++) begin
      fast_step("R5 R8 short step");
      if (s <= 64) hist[s-1] = noise_f;
      if (s > 65535)
        check(noise_f == hist[s-65536], "R5 period 65535", 24'(noise_f), 24'(hist[s-65536]));
      if (s <= 65535) begin
        run = noise_f ? run + 1 : 0;
        if (run > max_run) max_run = run;
      end
    end
    check(max_run == 15, "R9 longest ones run", 24'(max_run), 24'(15));
    // Switch to 24 stages.
    @(negedge clk);
    sel_f = 1'b0;
    j = 0;
    done = 1'b0;
    while (!done) begin
      if (stb_f) begin
        if (j + 1 >= 3) begin
          model_f = 24'h0;
          mode_f  = 1'b0;
          @(negedge clk); j++;
          check(noise_f == 1'b0, "R10 reload fast", 24'(noise_f), 24'(0));
          done = 1'b1;
        end else begin
          model_f = ref_step(model_f, mode_f);
          @(negedge clk); j++;
          check(noise_f == model_f[0], "R10 old length fast", 24'(noise_f), 24'(model_f[0]));
        end
      end else begin
        @(negedge clk); j++;
      end
    end
    for (int s = 0; s < 10000; s++) fast_step("R6 R7 long step");
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 198000; c++) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 198000, 0);
    summary();
  end

  initial begin
    rst   = 1'b1;
    sel_s = 1'b0;
    sel_f = 1'b1;
    repeat (4) @(negedge clk);
    check(noise_s == 1'b0, "R1 reset noise", 24'(noise_s), 24'(0));
    check(noise_f == 1'b0, "R1 reset noise fast", 24'(noise_f), 24'(0));
    rst = 1'b0;
    check(stb_s == 1'b0, "R1 reset strobe", 24'(stb_s), 24'(0));
    fork
      slow_proc();
      fast_proc();
    join
    summary();
  end
endmodule